// File: doc/BRIEF.md
# Shift-Register Push-Down Stack

This block is a last-in-first-out store. Its storage is a chain of word-wide register stages, not an addressed memory. Stage 0 is the top of the stack, and it is the only word the outside world can see. A push moves every stored word one stage deeper and loads the new word into stage 0. A pop moves every word one stage toward the top and loads zero into the deepest stage.

A separate up-down occupancy counter supplies the full and empty flags. A push while the stack is full is dropped, and so is a pop while it is empty. When push and pop arrive together on a non-empty stack, the top word is overwritten with the input data and the depth stays the same.

Top module: `shift_lifo`

## Requirements
- R1: After synchronous reset (rst high at a rising edge), empty_o is 1, full_o is 0 and top_o is 0. No word stored before the reset is visible afterwards.
- R2: A push alone on a non-full stack puts din on top_o from the next rising edge, and empty_o drops to 0.
- R3: Words come back out in the reverse of the order they were pushed.
- R4: A pop alone on a non-empty stack exposes the word that was beneath the top. Popping the last word makes top_o 0 and empty_o 1.
- R5: full_o is 1 exactly when the number of stored words equals DEPTH. empty_o is 1 exactly when that number is zero.
- R6: A push alone while full is ignored: top_o, full_o and all stored words stay unchanged.
- R7: A pop alone while empty is ignored: empty_o stays 1 and top_o stays 0, and a later push behaves normally.
- R8: Push and pop together on a non-empty stack replace the top word with din and leave the depth and the deeper words unchanged.
- R9: Push and pop together on an empty stack act as a plain push.
- R10: Positions vacated by pops read as zero, so top_o is 0 whenever the stack is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Request to store din on top |
| pop_i | input | 1 | Request to remove the top word |
| din | input | WIDTH | Word to be pushed |
| top_o | output | WIDTH | Current top-of-stack word |
| full_o | output | 1 | Stack holds DEPTH words |
| empty_o | output | 1 | Stack holds no words |

## Verification
Push and pop can be requested in the same cycle. The bench provokes this in three states: with the stack full, in the middle of its range, and empty. At full and mid-depth the top word must be replaced, and the following pops must show that the deeper words and the depth were untouched. On an empty stack the pair must act as a push, with empty_o falling. The bench also holds push while the stack is full and pop while it is empty, and then checks at top_o, and by popping everything out, that nothing changed.

// File: rtl/shift_lifo_pkg.sv
package shift_lifo_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic push;
        logic pop;
    } stk_req_t;

    // Resolve a request against the present flags into one accepted operation.
    function automatic stk_op_e stk_decode(stk_req_t req, logic is_full, logic is_empty);
        stk_op_e op;
        op = OP_HOLD;
        if (req.push && req.pop) begin
            op = is_empty ? OP_PUSH : OP_SWAP;
        end else if (req.push) begin
            op = is_full ? OP_HOLD : OP_PUSH;
        end else if (req.pop) begin
            op = is_empty ? OP_HOLD : OP_POP;
        end
        return op;
    endfunction

endpackage

// File: rtl/stk_occupancy.sv
module stk_occupancy
    import shift_lifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  stk_op_e op,
    output logic    full,
    output logic    empty
);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (op)
                OP_PUSH: count <= count + 1'b1;
                OP_POP:  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // R5: count never runs past the depth, and the two flags never coincide
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        (count <= CW'(DEPTH)) && !(full && empty));

    // R8: a replace-top cycle keeps occupancy
    a_r8_swap_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SWAP) |=> $stable(count));

endmodule

// File: rtl/stk_stage_chain.sv
module stk_stage_chain
    import shift_lifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] top
);

    logic [WIDTH-1:0] stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic [WIDTH-1:0] from_above;
        logic [WIDTH-1:0] from_below;
        logic [WIDTH-1:0] swap_val;

        if (i == 0) begin : g_top
            assign from_above = din;
            assign swap_val   = din;
        end else begin : g_mid
            assign from_above = stage[i-1];
            assign swap_val   = stage[i];
        end

        if (i == DEPTH - 1) begin : g_bot
            assign from_below = '0;
        end else begin : g_up
            assign from_below = stage[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage[i] <= '0;
            end else begin
                unique case (op)
                    OP_PUSH: stage[i] <= from_above;
                    OP_POP:  stage[i] <= from_below;
                    OP_SWAP: stage[i] <= swap_val;
                    default: stage[i] <= stage[i];
                endcase
            end
        end
    end

    assign top = stage[0];

    // R2: an accepted push lands the input word on top
    a_r2_push_to_top: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) |=> (top == $past(din)));

    if (DEPTH > 1) begin : g_chk
        // R4: a pop raises the second word to the top
        a_r4_pop_exposes: assert property (@(posedge clk) disable iff (rst)
            (op == OP_POP) |=> (top == $past(stage[1])));
        // R10: the deepest stage is cleared by a pop
        a_r10_bottom_zero: assert property (@(posedge clk) disable iff (rst)
            (op == OP_POP) |=> (stage[DEPTH-1] == '0));
    end

endmodule

// File: rtl/shift_lifo.sv
module shift_lifo
    import shift_lifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] top_o,
    output logic             full_o,
    output logic             empty_o
);

    stk_req_t req;
    stk_op_e  op;

    assign req = '{push: push_i, pop: pop_i};
    assign op  = stk_decode(req, full_o, empty_o);

    stk_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .full  (full_o),
        .empty (empty_o)
    );

    stk_stage_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chain (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .din (din),
        .top (top_o)
    );

    // R6: push alone while full leaves top and flags alone
    a_r6_full_push_ignored: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !pop_i) |=> ($stable(top_o) && full_o));

    // R7: pop alone while empty leaves the stack empty
    a_r7_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
        (empty_o && pop_i && !push_i) |=> (empty_o && top_o == '0));

    // R10: an empty stack shows a zero word
    a_r10_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> (top_o == '0));

    // R9: push with pop on an empty stack leaves it non-empty
    a_r9_empty_pair_pushes: assert property (@(posedge clk) disable iff (rst)
        (empty_o && push_i && pop_i) |=> (!empty_o && top_o == $past(din)));

endmodule

// File: tb/shift_lifo_test.sv
module shift_lifo_test;

    localparam int DEPTH = 4;
    localparam int WIDTH = 8;
    localparam int NV    = 17;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_i = 1'b0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] top_o;
    logic             full_o;
    logic             empty_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    shift_lifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .din     (din),
        .top_o   (top_o),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    // {push, pop, din, expected top, expected empty, expected full}
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h11, 8'h11, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h22, 8'h22, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h33, 8'h33, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h44, 8'h44, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'h55, 8'h44, 1'b0, 1'b1},
        {1'b1, 1'b1, 8'h66, 8'h66, 1'b0, 1'b1},
        {1'b0, 1'b1, 8'hA0, 8'h33, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'hA1, 8'h22, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'hA2, 8'h11, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'hA3, 8'h00, 1'b1, 1'b0},
        {1'b0, 1'b1, 8'hA4, 8'h00, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'h77, 8'h77, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h88, 8'h88, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h99, 8'h99, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'hA5, 8'h77, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'hA6, 8'h00, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'hA7, 8'h00, 1'b1, 1'b0}
    };

    function automatic string vec_req(int i);
        case (i)
            0, 1, 2: return "R2";
            3:       return "R5";
            4:       return "R6";
            5:       return "R8";
            6, 7, 8: return "R3";
            9:       return "R4";
            10:      return "R7";
            11:      return "R9";
            13:      return "R8";
            15, 16:  return "R10";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string req, logic [WIDTH-1:0] et, logic ee, logic ef);
        checks++;
        if (top_o !== et || empty_o !== ee || full_o !== ef) begin
            fails++;
            $display("FAIL %s: top=%h empty=%b full=%b expected top=%h empty=%b full=%b",
                     req, top_o, empty_o, full_o, et, ee, ef);
        end
    endtask

    task automatic step(logic pu, logic po, logic [WIDTH-1:0] d);
        @(negedge clk);
        push_i = pu;
        pop_i  = po;
        din    = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R1", 8'h00, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][19], VEC[i][18], VEC[i][17:10]);
            check(vec_req(i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R3: reverse order with a fresh pattern
        for (int k = 0; k < DEPTH; k++) step(1'b1, 1'b0, 8'(8'hC0 + k * 7));
        check("R5", 8'(8'hC0 + (DEPTH - 1) * 7), 1'b0, 1'b1);
        for (int k = DEPTH - 1; k >= 1; k--) begin
            step(1'b0, 1'b1, 8'h00);
            check("R3", 8'(8'hC0 + (k - 1) * 7), 1'b0, 1'b0);
        end
        step(1'b0, 1'b1, 8'h00);
        check("R10", 8'h00, 1'b1, 1'b0);

        // R8 mid-depth: replace keeps the deeper word and the depth
        step(1'b1, 1'b0, 8'h5A);
        step(1'b1, 1'b0, 8'h6B);
        step(1'b1, 1'b1, 8'h7C);
        check("R8", 8'h7C, 1'b0, 1'b0);
        step(1'b0, 1'b1, 8'h00);
        check("R8", 8'h5A, 1'b0, 1'b0);
        step(1'b0, 1'b1, 8'h00);
        check("R8", 8'h00, 1'b1, 1'b0);

        // R6: pushes while full leave the stored words intact
        for (int k = 0; k < DEPTH; k++) step(1'b1, 1'b0, 8'(8'h10 + k));
        step(1'b1, 1'b0, 8'hEE);
        step(1'b1, 1'b0, 8'hEF);
        check("R6", 8'(8'h10 + DEPTH - 1), 1'b0, 1'b1);
        for (int k = DEPTH - 1; k >= 0; k--) begin
            check("R6", 8'(8'h10 + k), 1'b0, k == DEPTH - 1);
            step(1'b0, 1'b1, 8'h00);
        end
        check("R10", 8'h00, 1'b1, 1'b0);

        // R7: repeated empty pops, then a normal push and pop
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        check("R7", 8'h00, 1'b1, 1'b0);
        step(1'b1, 1'b0, 8'h3C);
        check("R7", 8'h3C, 1'b0, 1'b0);
        step(1'b0, 1'b1, 8'h00);
        check("R7", 8'h00, 1'b1, 1'b0);

        // R1: reset mid-stream hides earlier words
        step(1'b1, 1'b0, 8'hAA);
        step(1'b1, 1'b0, 8'hBB);
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        rst    = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 8'h00, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b0, 8'hCC);
        step(1'b0, 1'b1, 8'h00);
        check("R1", 8'h00, 1'b1, 1'b0);
        step(1'b0, 1'b0, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule